// File: doc/BRIEF.md
# Thread Join Slot Engine

This block is the synchronization engine of one node in a multithreaded processor. It takes three kinds of request, each on its own valid/ready channel. A local spawn hands over a frame pointer and an instruction pointer, and that pair goes straight into a queue of threads that are ready to run. A local sync names a join slot in frame memory as a frame pointer plus a slot offset. A network message carries a 32-bit value, a future offset and a slot offset.

Each join slot is one 32-bit word in a small local frame memory. The word holds a countdown, the value the countdown reloads to, and the pointer to the thread that runs when the countdown expires. A sync decrements the countdown. When it expires, the slot reloads itself and a fire record is queued, made of the requester's frame pointer and the slot's thread pointer. Because the slot reloads, the same join can fire again and again, for example on each pass of a loop. A network message first writes its value into the frame and then updates a slot in the same way.

The execution side takes fire records from an 8-entry first-in first-out queue through a valid/take port.

Top module: `tsu_sync_unit`

## Requirements
- R1: A slot word has the countdown in bits 31:29, the reload value in bits 28:26 and the thread pointer in bits 25:0. When a sync decrements a countdown from c > 1, the word is written back with countdown c-1, the other fields are unchanged, and no fire record is queued.
- R2: When a countdown of 1 is decremented, the slot's countdown becomes its reload value. A fire record is queued with the requester's frame pointer and the slot's thread pointer.
- R3: A countdown that is already 0 when it is decremented is treated as 1. The slot fires and reloads as in R2, and the countdown does not wrap to 7.
- R4: An accepted spawn queues a fire record carrying its own frame pointer and instruction pointer, with no access to frame memory. The record is visible on the fire port in the cycle after the spawn is accepted.
- R5: A network message writes its value to address fp+future_offset before it reads the slot at fp+slot_offset. When the two addresses are equal, the slot update works on the value just written.
- R6: When several requests are pending, the network message is accepted first, then the sync, then the spawn. At most one request is accepted per cycle.
- R7: After it accepts a sync, the block accepts no request for 2 cycles; after it accepts a message, for 3 cycles. Any fire record from a sync appears on the fire port 2 cycles after the sync is accepted.
- R8: No request is accepted while the 8-entry fire queue is full. Fire records leave the queue in the order they were queued.
- R9: While a fire record is offered and not taken, the fire port keeps its frame pointer and instruction pointer unchanged.
- R10: A slot or future address is the frame pointer plus the offset, taken modulo the size of the frame memory.
- R11: After reset the fire queue is empty and all three request channels are ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spawn_valid | input | 1 | Spawn request present |
| spawn_ready | output | 1 | Spawn request accepted this cycle if valid |
| spawn_fp | input | FP_W | Frame pointer of the spawned thread |
| spawn_ip | input | 26 | First instruction of the spawned thread |
| sync_valid | input | 1 | Sync request present |
| sync_ready | output | 1 | Sync request accepted this cycle if valid |
| sync_fp | input | FP_W | Frame pointer of the sync |
| sync_slot_off | input | OFF_W | Slot offset within the frame |
| net_valid | input | 1 | Network message present |
| net_ready | output | 1 | Network message accepted this cycle if valid |
| net_fp | input | FP_W | Frame pointer of the message |
| net_fut_off | input | OFF_W | Future offset within the frame |
| net_slot_off | input | OFF_W | Slot offset within the frame |
| net_value | input | 32 | Value stored at the future address |
| fire_valid | output | 1 | A fire record is offered |
| fire_take | input | 1 | Consumer takes the offered record |
| fire_fp | output | FP_W | Frame pointer of the offered record |
| fire_ip | output | 26 | Instruction pointer of the offered record |

## Verification
The bench builds the block with FP_W=5, OFF_W=3 and an 8-entry queue, so the frame memory has 32 words, and every slot address can be reached by some pair of frame pointer and offset in range, including pairs that wrap. This small memory makes it possible to sweep all 64 pairs of countdown and reload value and to run each slot through more than a full reload period, so the zero-count case and the reload-to-zero case both appear. It also allows every frame pointer to be spawned, the queue to be filled to its limit, and address wrap-around to be checked directly.

// File: rtl/tsu_pkg.sv
`timescale 1ns/1ps
package tsu_pkg;
  localparam int SLOT_W = 32;
  localparam int CNT_W  = 3;
  localparam int TP_W   = 26;

  // Packed order gives countdown 31:29, reload 28:26, thread pointer 25:0.
  typedef struct packed {
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] rld;
    logic [TP_W-1:0]  tp;
  } slot_t;

  typedef enum logic [1:0] {S_IDLE, S_FUT, S_RD, S_WR} state_t;
endpackage

// File: rtl/tsu_slot_update.sv
`timescale 1ns/1ps
module tsu_slot_update
  import tsu_pkg::*;
(
  input  slot_t cur,
  output slot_t nxt,
  output logic  fire
);
  logic [CNT_W-1:0] eff;
  logic [CNT_W-1:0] dec;

  always_comb begin
    eff  = (cur.cnt == '0) ? CNT_W'(1) : cur.cnt;
    dec  = eff - CNT_W'(1);
    fire = (dec == '0);
    nxt  = cur;
    nxt.cnt = fire ? cur.rld : dec;
  end
endmodule

// File: rtl/tsu_frame_mem.sv
`timescale 1ns/1ps
module tsu_frame_mem #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  initial begin
    for (int i = 0; i < WORDS; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/tsu_ready_fifo.sv
`timescale 1ns/1ps
module tsu_ready_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         full,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         take
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_pop;

  assign full      = (count == CW'(DEPTH));
  assign out_valid = (count != '0);
  assign out_data  = store[rd_ptr];
  assign do_pop    = take && out_valid;

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push)
        wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
      if (do_pop)
        rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
      case ({push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/tsu_sync_unit.sv
`timescale 1ns/1ps
module tsu_sync_unit
  import tsu_pkg::*;
#(
  parameter int FP_W       = 6,
  parameter int OFF_W      = 3,
  parameter int FIFO_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             spawn_valid,
  output logic             spawn_ready,
  input  logic [FP_W-1:0]  spawn_fp,
  input  logic [TP_W-1:0]  spawn_ip,
  input  logic             sync_valid,
  output logic             sync_ready,
  input  logic [FP_W-1:0]  sync_fp,
  input  logic [OFF_W-1:0] sync_slot_off,
  input  logic             net_valid,
  output logic             net_ready,
  input  logic [FP_W-1:0]  net_fp,
  input  logic [OFF_W-1:0] net_fut_off,
  input  logic [OFF_W-1:0] net_slot_off,
  input  logic [SLOT_W-1:0] net_value,
  output logic             fire_valid,
  input  logic             fire_take,
  output logic [FP_W-1:0]  fire_fp,
  output logic [TP_W-1:0]  fire_ip
);
  localparam int REC_W = FP_W + TP_W;

  state_t            state;
  logic [FP_W-1:0]   op_fp;
  logic [FP_W-1:0]   fut_addr;
  logic [FP_W-1:0]   slot_addr;
  logic [SLOT_W-1:0] op_value;

  logic              fifo_full;
  logic              can_take;
  logic              net_go, sync_go, spawn_go;

  logic              mem_we;
  logic [FP_W-1:0]   mem_addr;
  logic [SLOT_W-1:0] mem_wdata;
  logic [SLOT_W-1:0] mem_rdata;

  slot_t             cur_slot, nxt_slot;
  logic              slot_fire;

  logic              push;
  logic [REC_W-1:0]  push_rec;
  logic [REC_W-1:0]  head_rec;

  // Fixed priority: network, then sync, then spawn.
  assign can_take    = (state == S_IDLE) && !fifo_full;
  assign net_ready   = can_take;
  assign sync_ready  = can_take && !net_valid;
  assign spawn_ready = can_take && !net_valid && !sync_valid;
  assign net_go      = net_valid && net_ready;
  assign sync_go     = sync_valid && sync_ready;
  assign spawn_go    = spawn_valid && spawn_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE: begin
          if (net_go)       state <= S_FUT;
          else if (sync_go) state <= S_RD;
        end
        S_FUT:   state <= S_RD;
        S_RD:    state <= S_WR;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (net_go) begin
      op_fp     <= net_fp;
      fut_addr  <= net_fp + FP_W'(net_fut_off);
      slot_addr <= net_fp + FP_W'(net_slot_off);
      op_value  <= net_value;
    end else if (sync_go) begin
      op_fp     <= sync_fp;
      slot_addr <= sync_fp + FP_W'(sync_slot_off);
    end
  end

  // One memory port; the read and write-back of a slot are back to back.
  always_comb begin
    mem_we    = 1'b0;
    mem_addr  = slot_addr;
    mem_wdata = nxt_slot;
    case (state)
      S_FUT: begin
        mem_we    = 1'b1;
        mem_addr  = fut_addr;
        mem_wdata = op_value;
      end
      S_WR:    mem_we = 1'b1;
      default: ;
    endcase
  end

  tsu_frame_mem #(.AW(FP_W), .DW(SLOT_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

  assign cur_slot = slot_t'(mem_rdata);

  tsu_slot_update u_upd (
    .cur  (cur_slot),
    .nxt  (nxt_slot),
    .fire (slot_fire)
  );

  always_comb begin
    push     = 1'b0;
    push_rec = {spawn_fp, spawn_ip};
    if (state == S_WR && slot_fire) begin
      push     = 1'b1;
      push_rec = {op_fp, cur_slot.tp};
    end else if (spawn_go) begin
      push = 1'b1;
    end
  end

  tsu_ready_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_data (push_rec),
    .full      (fifo_full),
    .out_valid (fire_valid),
    .out_data  (head_rec),
    .take      (fire_take)
  );

  assign fire_fp = head_rec[REC_W-1:TP_W];
  assign fire_ip = head_rec[TP_W-1:0];
endmodule

// File: rtl/tsu_sync_chk.sv
`timescale 1ns/1ps
module tsu_sync_chk #(
  parameter int FP_W = 6,
  parameter int TP_W = 26
) (
  input logic            clk,
  input logic            rst,
  input logic            spawn_valid,
  input logic            spawn_ready,
  input logic            sync_valid,
  input logic            sync_ready,
  input logic            net_valid,
  input logic            net_ready,
  input logic            fire_valid,
  input logic            fire_take,
  input logic [FP_W-1:0] fire_fp,
  input logic [TP_W-1:0] fire_ip
);
  // R6
  one_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({net_valid && net_ready, sync_valid && sync_ready, spawn_valid && spawn_ready}));

  // R6
  net_first_chk: assert property (@(posedge clk) disable iff (rst)
    net_valid |-> (!sync_ready && !spawn_ready));

  // R7
  net_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (net_valid && net_ready) |=> (!net_ready && !sync_ready && !spawn_ready));

  // R7
  sync_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (sync_valid && sync_ready) |=> (!net_ready && !sync_ready && !spawn_ready));

  // R4
  spawn_fire_chk: assert property (@(posedge clk) disable iff (rst)
    (spawn_valid && spawn_ready) |=> fire_valid);

  // R9
  fire_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fire_valid && !fire_take) |=> (fire_valid && $stable(fire_fp) && $stable(fire_ip)));
endmodule

bind tsu_sync_unit tsu_sync_chk #(.FP_W(FP_W), .TP_W(tsu_pkg::TP_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .spawn_valid (spawn_valid),
  .spawn_ready (spawn_ready),
  .sync_valid  (sync_valid),
  .sync_ready  (sync_ready),
  .net_valid   (net_valid),
  .net_ready   (net_ready),
  .fire_valid  (fire_valid),
  .fire_take   (fire_take),
  .fire_fp     (fire_fp),
  .fire_ip     (fire_ip)
);

// File: tb/sim_tsu_sync_unit.sv
`timescale 1ns/1ps
module sim_tsu_sync_unit;
  localparam int FP_W  = 5;
  localparam int OFF_W = 3;
  localparam int WORDS = 1 << FP_W;

  logic clk = 0;
  logic rst = 1;
  logic spawn_valid = 0, sync_valid = 0, net_valid = 0, fire_take = 0;
  logic spawn_ready, sync_ready, net_ready, fire_valid;
  logic [FP_W-1:0] spawn_fp = 0, sync_fp = 0, net_fp = 0, fire_fp;
  logic [25:0] spawn_ip = 0, fire_ip;
  logic [OFF_W-1:0] sync_slot_off = 0, net_fut_off = 0, net_slot_off = 0;
  logic [31:0] net_value = 0;

  int n_chk = 0, n_fail = 0;
  logic [31:0] ref_mem [WORDS];
  int q_fp [256];
  int q_ip [256];
  int q_wr = 0, q_rd = 0;

  always #10 clk = ~clk;

  tsu_sync_unit #(.FP_W(FP_W), .OFF_W(OFF_W), .FIFO_DEPTH(8)) u0 (
    .clk(clk), .rst(rst),
    .spawn_valid(spawn_valid), .spawn_ready(spawn_ready), .spawn_fp(spawn_fp), .spawn_ip(spawn_ip),
    .sync_valid(sync_valid), .sync_ready(sync_ready), .sync_fp(sync_fp), .sync_slot_off(sync_slot_off),
    .net_valid(net_valid), .net_ready(net_ready), .net_fp(net_fp), .net_fut_off(net_fut_off),
    .net_slot_off(net_slot_off), .net_value(net_value),
    .fire_valid(fire_valid), .fire_take(fire_take), .fire_fp(fire_fp), .fire_ip(fire_ip)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void q_push(int fp, int ip);
    q_fp[q_wr % 256] = fp;
    q_ip[q_wr % 256] = ip;
    q_wr++;
  endfunction

  // Slot arithmetic from R1-style field layout: countdown 31:29, reload 28:26, pointer 25:0.
  function automatic void model_slot(int fp, int addr);
    logic [31:0] w;
    logic [2:0] c;
    w = ref_mem[addr];
    c = (w[31:29] == 3'd0) ? 3'd1 : w[31:29];
    c = c - 3'd1;
    if (c == 3'd0) begin
      ref_mem[addr] = {w[28:26], w[28:26], w[25:0]};
      q_push(fp, int'(w[25:0]));
    end else begin
      ref_mem[addr] = {c, w[28:0]};
    end
  endfunction

  task automatic send_net(input int fp, input int fo, input int so, input logic [31:0] val);
    @(negedge clk);
    net_fp = FP_W'(fp); net_fut_off = OFF_W'(fo); net_slot_off = OFF_W'(so);
    net_value = val; net_valid = 1;
    while (!net_ready) @(negedge clk);
    @(posedge clk);
    #1 net_valid = 0;
    ref_mem[(fp + fo) % WORDS] = val;
    model_slot(fp, (fp + so) % WORDS);
    repeat (3) @(posedge clk);
  endtask

  task automatic send_sync(input int fp, input int so);
    @(negedge clk);
    sync_fp = FP_W'(fp); sync_slot_off = OFF_W'(so); sync_valid = 1;
    while (!sync_ready) @(negedge clk);
    @(posedge clk);
    #1 sync_valid = 0;
    model_slot(fp, (fp + so) % WORDS);
    repeat (2) @(posedge clk);
  endtask

  task automatic send_spawn(input int fp, input int ip);
    @(negedge clk);
    spawn_fp = FP_W'(fp); spawn_ip = 26'(ip); spawn_valid = 1;
    while (!spawn_ready) @(negedge clk);
    @(posedge clk);
    #1 spawn_valid = 0;
    q_push(fp, ip);
  endtask

  task automatic drain(input string req);
    @(negedge clk);
    while (q_rd != q_wr) begin
      chk(fire_valid == 1'b1, req, fire_valid, 1);
      chk(int'(fire_fp) == q_fp[q_rd % 256], req, fire_fp, q_fp[q_rd % 256]);
      chk(int'(fire_ip) == q_ip[q_rd % 256], req, fire_ip, q_ip[q_rd % 256]);
      fire_take = 1;
      @(posedge clk);
      #1 fire_take = 0;
      q_rd++;
      @(negedge clk);
    end
    chk(fire_valid == 1'b0, req, fire_valid, 0);
  endtask

  task automatic sync_and_check(input int fp, input int so);
    logic [2:0] c;
    string tag;
    c = ref_mem[(fp + so) % WORDS][31:29];
    if (c == 3'd0)      tag = "R3 zero count fires";
    else if (c == 3'd1) tag = "R2 expiry reloads and fires";
    else                tag = "R1 decrement without fire";
    send_sync(fp, so);
    drain(tag);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R11
    chk(fire_valid == 0, "R11 queue empty", fire_valid, 0);
    chk(net_ready && sync_ready && spawn_ready, "R11 all ready",
        {net_ready, sync_ready, spawn_ready}, 3'b111);

    // R4: every frame pointer, record visible the cycle after acceptance
    for (int fp = 0; fp < WORDS; fp++) begin
      send_spawn(fp, (fp * 12345 + 7) % (1 << 26));
      @(negedge clk);
      chk(fire_valid == 1, "R4 spawn visible next cycle", fire_valid, 1);
      drain("R4 spawn record");
    end

    // Sweep all countdown / reload pairs through more than one reload period.
    for (int c = 0; c < 8; c++) begin
      for (int r = 0; r < 8; r++) begin
        int addr, so, fp;
        addr = (c * 8 + r) % WORDS;
        so   = (c + r) % 8;
        fp   = (addr - so + WORDS) % WORDS;
        send_net(fp, so, so, {3'(c), 3'(r), 26'(c * 64 + r + 100)});
        drain("R5 same-address future then slot");
        for (int k = 0; k < 10; k++) sync_and_check(fp, so);
      end
    end

    // R5: future and slot at different addresses
    send_net(4, 1, 2, {3'd1, 3'd3, 26'h55});
    drain("R5 slot update after store");
    send_sync(4, 1);
    drain("R5 stored value read back through slot");

    // R10: wrap modulo memory size
    send_net(30, 5, 5, {3'd1, 3'd2, 26'h1234});
    drain("R10 wrapped message address");
    send_sync(0, 3);
    drain("R10 wrapped slot decrement");
    send_sync(1, 2);
    drain("R10 wrapped slot fire");

    // R7: sync latency and busy window
    send_net(8, 0, 0, {3'd2, 3'd2, 26'h2a});
    drain("R7 setup");
    @(negedge clk);
    sync_fp = 5'd8; sync_slot_off = 0; sync_valid = 1;
    @(posedge clk);
    #1 sync_valid = 0;
    @(negedge clk);
    chk(!sync_ready && !net_ready && !spawn_ready, "R7 busy after sync 1",
        {net_ready, sync_ready, spawn_ready}, 0);
    chk(fire_valid == 0, "R7 no early fire", fire_valid, 0);
    @(negedge clk);
    chk(!sync_ready && !net_ready && !spawn_ready, "R7 busy after sync 2",
        {net_ready, sync_ready, spawn_ready}, 0);
    chk(fire_valid == 0, "R7 no early fire 2", fire_valid, 0);
    @(negedge clk);
    chk(fire_valid == 1, "R7 fire at two cycles", fire_valid, 1);
    chk(sync_ready == 1, "R7 ready again", sync_ready, 1);
    model_slot(8, 8);
    drain("R7 fire record");

    // R8: fill the queue, then everything stalls; order kept
    for (int i = 0; i < 8; i++) send_spawn(i + 3, 1000 + i);
    @(negedge clk);
    spawn_valid = 1; spawn_fp = 0; spawn_ip = 0;
    @(negedge clk);
    chk(!spawn_ready && !sync_ready && !net_ready, "R8 stall when full",
        {net_ready, sync_ready, spawn_ready}, 0);
    spawn_valid = 0;
    drain("R8 queue order");

    // R6: all three pending together
    send_net(12, 0, 0, {3'd3, 3'd1, 26'h77});
    drain("R6 setup");
    @(negedge clk);
    net_fp = 12; net_fut_off = 1; net_slot_off = 0; net_value = 32'h0;
    sync_fp = 12; sync_slot_off = 0;
    spawn_fp = 9; spawn_ip = 26'h999;
    net_valid = 1; sync_valid = 1; spawn_valid = 1;
    #1;
    chk(net_ready && !sync_ready && !spawn_ready, "R6 network first",
        {net_ready, sync_ready, spawn_ready}, 3'b100);
    @(posedge clk);
    #1 net_valid = 0;
    ref_mem[13] = 32'h0;
    model_slot(12, 12);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(sync_ready && !spawn_ready, "R6 sync before spawn",
        {sync_ready, spawn_ready}, 2'b10);
    @(posedge clk);
    #1 sync_valid = 0;
    model_slot(12, 12);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(spawn_ready == 1, "R6 spawn last", spawn_ready, 1);
    @(posedge clk);
    #1 spawn_valid = 0;
    q_push(9, 'h999);
    drain("R6 grant order");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule